// File: doc/BRIEF.md
# Carry select adder

This block adds two unsigned or two's-complement operands of `DATA_WIDTH` bits plus a one-bit carry, with no clock and no storage. The operand width is cut into equal slices of `BLOCK_SIZE` bits. The bottom slice is a single ripple chain fed by the incoming carry. Every slice above it holds two ripple chains working at the same time. One chain assumes that no carry arrives and the other assumes that one does. When the true carry from the slice below settles, a multiplexer picks the matching sum bits and carry-out. The critical path is one short ripple plus one multiplexer level per slice, not a ripple through every bit.

Two flags come out with the sum. The carry flag is the final carry out of the top slice and marks unsigned overflow. The overflow flag marks a signed result that does not fit in `DATA_WIDTH` bits. The block does not subtract by itself. To subtract, the caller inverts the second operand and raises the incoming carry. Because the design is purely combinational it has no states and no transitions. A width that is not a whole multiple of the slice size stops elaboration with an error.

Top module: `csel_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^`DATA_WIDTH`, for every input combination.
- R2: `carry_flag` equals bit `DATA_WIDTH` of the unsigned sum `op_a` + `op_b` + `carry_in`, taken at `DATA_WIDTH`+1 bits.
- R3: `ovf_flag` is 1 exactly when the two's-complement sum of `op_a`, `op_b` and `carry_in` lies outside the signed range of `DATA_WIDTH` bits. Examples: 0x7FFF+0x0001 and 0x8000+0xFFFF set it, and 0x8000+0x8000 sets both flags.
- R4: With `op_b` set to the bitwise inverse of the subtrahend and `carry_in` = 1, `sum` is the difference modulo 2^`DATA_WIDTH`. `carry_flag` is 1 when no borrow occurs and 0 when one does.
- R5: A carry entering the bottom slice reaches the top through slices that all propagate. For example, 0xFFFF + 0x0000 + 1 gives `sum` 0x0000 with `carry_flag` 1.
- R6: A slice whose incoming carry is 1 presents the result of its carry-assumed-one chain, and otherwise the result of its carry-assumed-zero chain. For example, 0x000F+0x0001 gives 0x0010 and 0x0F0F+0x00F1 gives 0x1000.
- R7: With `op_b` = 0 and `carry_in` = 0, `sum` equals `op_a`, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DATA_WIDTH | First operand |
| op_b | input | DATA_WIDTH | Second operand (already inverted by the caller for subtraction) |
| carry_in | input | 1 | Carry into the least significant bit |
| sum | output | DATA_WIDTH | Result bits |
| carry_flag | output | 1 | Final carry out, unsigned overflow |
| ovf_flag | output | 1 | Signed overflow |

## Verification
The hardest case to reach from the ports is one where the selection in every slice depends on a carry made several slices below. The stimulus needs slices that all propagate, sitting above a slice that generates a carry. A random operand almost never lines this up. The stimulus table therefore holds operands built for this case, such as all ones plus a carry, or alternating nibbles of 0xF and 0x0 that force each slice to take its carry-assumed-one result. These are then mixed with pseudo-random pairs so that the carry-assumed-zero path and the sign boundaries are also covered.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Carry value each speculative chain inside a slice assumes
    typedef enum logic {
        SPEC_C0 = 1'b0,
        SPEC_C1 = 1'b1
    } spec_e;

    // Number of slices for a given width and slice size
    function automatic int slice_count(input int width, input int slice);
        return width / slice;
    endfunction

    // True when the width splits into whole slices
    function automatic bit slice_fit(input int width, input int slice);
        return (slice > 0) && (width % slice == 0);
    endfunction

endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;

    assign prop = a ^ b;
    assign gen  = a & b;

    always_comb begin
        chain[0] = cin;
        for (int i = 0; i < WIDTH; i++) begin
            sum[i]       = prop[i] ^ chain[i];
            chain[i + 1] = gen[i] | (prop[i] & chain[i]);
        end
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/csel_spec_slice.sv
module csel_spec_slice
    import csel_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sel_carry,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] sum_c0;
    logic [WIDTH-1:0] sum_c1;
    logic             cout_c0;
    logic             cout_c1;
    spec_e            pick;

    csel_rca #(.WIDTH(WIDTH)) u_chain_c0 (
        .a    (a),
        .b    (b),
        .cin  (SPEC_C0),
        .sum  (sum_c0),
        .cout (cout_c0)
    );

    csel_rca #(.WIDTH(WIDTH)) u_chain_c1 (
        .a    (a),
        .b    (b),
        .cin  (SPEC_C1),
        .sum  (sum_c1),
        .cout (cout_c1)
    );

    assign pick = spec_e'(sel_carry);

    always_comb begin
        unique case (pick)
            SPEC_C1: begin
                sum  = sum_c1;
                cout = cout_c1;
            end
            default: begin
                sum  = sum_c0;
                cout = cout_c0;
            end
        endcase
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
#(
    parameter int DATA_WIDTH = 16,
    parameter int BLOCK_SIZE = 4
) (
    input  logic [DATA_WIDTH-1:0] op_a,
    input  logic [DATA_WIDTH-1:0] op_b,
    input  logic                  carry_in,
    output logic [DATA_WIDTH-1:0] sum,
    output logic                  carry_flag,
    output logic                  ovf_flag
);
    localparam int NSLICE = slice_count(DATA_WIDTH, BLOCK_SIZE);
    localparam int MSB    = DATA_WIDTH - 1;

    if (!slice_fit(DATA_WIDTH, BLOCK_SIZE)) begin : g_bad_size
        $error("csel_adder: DATA_WIDTH must be a whole multiple of BLOCK_SIZE");
    end

    // Carry between slices; index k enters slice k
    logic [NSLICE:0] slice_carry;
    assign slice_carry[0] = carry_in;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        localparam int LO = s * BLOCK_SIZE;
        if (s == 0) begin : g_base
            // Incoming carry is known, one chain suffices
            csel_rca #(.WIDTH(BLOCK_SIZE)) u_base (
                .a    (op_a[LO +: BLOCK_SIZE]),
                .b    (op_b[LO +: BLOCK_SIZE]),
                .cin  (slice_carry[s]),
                .sum  (sum[LO +: BLOCK_SIZE]),
                .cout (slice_carry[s + 1])
            );
        end else begin : g_spec
            csel_spec_slice #(.WIDTH(BLOCK_SIZE)) u_spec (
                .a         (op_a[LO +: BLOCK_SIZE]),
                .b         (op_b[LO +: BLOCK_SIZE]),
                .sel_carry (slice_carry[s]),
                .sum       (sum[LO +: BLOCK_SIZE]),
                .cout      (slice_carry[s + 1])
            );
        end
    end

    assign carry_flag = slice_carry[NSLICE];

    // Signed overflow: like-signed operands giving a result of the other sign
    assign ovf_flag = (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB]);
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
    parameter int DATA_WIDTH = 16
) (
    input logic [DATA_WIDTH-1:0] op_a,
    input logic [DATA_WIDTH-1:0] op_b,
    input logic                  carry_in,
    input logic [DATA_WIDTH-1:0] sum,
    input logic                  carry_flag,
    input logic                  ovf_flag
);
    localparam int W = DATA_WIDTH;

    logic [W:0] uref;
    logic [W:0] sref;
    logic       known;

    assign known = !$isunknown({op_a, op_b, carry_in, sum, carry_flag, ovf_flag});
    assign uref  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
    assign sref  = {op_a[W-1], op_a} + {op_b[W-1], op_b} + {{W{1'b0}}, carry_in};

    always_comb begin
        if (known) begin
            p_sum_r1: assert (sum == uref[W-1:0]);
            p_carry_r2: assert (carry_flag == uref[W]);
            p_no_overflow_r3: assert (ovf_flag == (sref[W] != sref[W-1]));
            if (op_b == '0 && !carry_in) begin
                p_identity_r7: assert (sum == op_a && !carry_flag && !ovf_flag);
            end
            if (&(op_a ^ op_b) && carry_in) begin
                p_full_prop_r5: assert (sum == '0 && carry_flag);
            end
        end
    end
endmodule

bind csel_adder csel_adder_chk #(.DATA_WIDTH(DATA_WIDTH)) u_chk (
    .op_a       (op_a),
    .op_b       (op_b),
    .carry_in   (carry_in),
    .sum        (sum),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/csel_adder_tb.sv
`timescale 1ns/1ps
module csel_adder_tb;
    localparam int DW = 16;
    localparam int BS = 4;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic          carry_in = 1'b0;
    logic [DW-1:0] sum;
    logic          carry_flag;
    logic          ovf_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    csel_adder #(.DATA_WIDTH(DW), .BLOCK_SIZE(BS)) u_dut (
        .op_a       (op_a),
        .op_b       (op_b),
        .carry_in   (carry_in),
        .sum        (sum),
        .carry_flag (carry_flag),
        .ovf_flag   (ovf_flag)
    );

    // Stimulus {a, b, cin}; expected results are computed below
    localparam logic [2*DW:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0},
        {16'hFFFF, 16'h0001, 1'b0},   // R5 full ripple
        {16'h7FFF, 16'h0001, 1'b0},   // R3 positive overflow
        {16'h8000, 16'h8000, 1'b0},   // R3 and R2 together
        {16'h1234, 16'h5678, 1'b1},
        {16'hFFFF, 16'hFFFF, 1'b1},
        {16'h000F, 16'h0001, 1'b0},   // R6 boundary
        {16'h0FFF, 16'h0000, 1'b1},   // R6 three slices
        {16'h00F0, 16'h0010, 1'b0},
        {16'hA5A5, 16'h5A5A, 1'b1},   // R5 all propagate
        {16'h8000, 16'hFFFF, 1'b0},   // R3 negative overflow
        {16'h7FFF, 16'h7FFF, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at a rising edge, check at the following falling edge
    task automatic apply_ref(input logic [DW-1:0] a, input logic [DW-1:0] b,
                             input logic c, input string req);
        logic [DW:0] u;
        logic [DW:0] s;
        @(posedge clk);
        op_a = a; op_b = b; carry_in = c;
        @(negedge clk);
        u = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
        s = {a[DW-1], a} + {b[DW-1], b} + {{DW{1'b0}}, c};
        check({req, "/R1"}, "sum", sum, u[DW-1:0]);
        check({req, "/R2"}, "carry", {{(DW-1){1'b0}}, carry_flag}, {{(DW-1){1'b0}}, u[DW]});
        check({req, "/R3"}, "ovf", {{(DW-1){1'b0}}, ovf_flag},
              {{(DW-1){1'b0}}, (s[DW] != s[DW-1])});
    endtask

    task automatic apply_lit(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic c,
                             input logic [DW-1:0] es, input logic ec, input logic eo,
                             input string req);
        @(posedge clk);
        op_a = a; op_b = b; carry_in = c;
        @(negedge clk);
        check(req, "sum", sum, es);
        check(req, "carry", {{(DW-1){1'b0}}, carry_flag}, {{(DW-1){1'b0}}, ec});
        check(req, "ovf", {{(DW-1){1'b0}}, ovf_flag}, {{(DW-1){1'b0}}, eo});
    endtask

    initial begin
        logic [31:0] lfsr;
        // Outputs with zero inputs while the bench holds reset (R7)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", "reset sum", sum, '0);
        check("R7", "reset carry", {{(DW-1){1'b0}}, carry_flag}, '0);
        check("R7", "reset ovf", {{(DW-1){1'b0}}, ovf_flag}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply_ref(VEC[i][2*DW:DW+1], VEC[i][DW:1], VEC[i][0], "VEC");
        end

        // R4 subtraction by inverted subtrahend and carry 1
        apply_lit(16'h0005, ~16'h0003, 1'b1, 16'h0002, 1'b1, 1'b0, "R4 5-3");
        apply_lit(16'h0003, ~16'h0005, 1'b1, 16'hFFFE, 1'b0, 1'b0, "R4 3-5");
        apply_lit(16'h8000, ~16'h0001, 1'b1, 16'h7FFF, 1'b1, 1'b1, "R4 min-1");
        // R5 carry from the bottom slice through every slice
        apply_lit(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, "R5");
        // R6 slice selection across boundaries
        apply_lit(16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, 1'b0, "R6 one");
        apply_lit(16'h0F0F, 16'h00F1, 1'b0, 16'h1000, 1'b0, 1'b0, "R6 alt");
        apply_lit(16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0, 1'b0, "R6 two");
        // R7 identity
        apply_lit(16'hABCD, 16'h0000, 1'b0, 16'hABCD, 1'b0, 1'b0, "R7");

        lfsr = 32'hC0DE_1357;
        for (int k = 0; k < 300; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            apply_ref(lfsr[31:16], lfsr[15:0] ^ lfsr[31:16] ^ {lfsr[7:0], lfsr[15:8]},
                      lfsr[3], "RND");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule